// File: doc/BRIEF.md
# Segmented Current-Steering Switch Decoder

This block converts a 12-bit sample word into the switch drive for a segmented current-steering converter. The word is split into three fields. The top five bits pick how many of 31 equal coarse cells steer to the primary output node. The next four bits pick how many of 15 equal middle cells steer there; each middle cell carries one sixteenth of a coarse cell. The bottom three bits drive three binary-weighted cells directly.

Every cell has a matched pair of drive lines, `*_on_o` and `*_off_o`. The `on` line steers the cell to the primary node and the `off` line steers it to the complementary node. The two lines of a pair are always opposite, so each cell is connected to exactly one node. The sample word passes through two register stages. The first latches the input word. The second holds all the decoded drive lines, so every switch changes on the same clock edge.

A user drives one code per clock and reads the switch pattern for that code two edges later. The three field widths are parameters. The coarse and middle arrays are sized from them.

Top module: `segdac_switch_driver`

## Requirements
- R1: A code present at `code_i` at clock edge k appears on the drive outputs after edge k+1 (two register stages), and the outputs then hold until the next edge.
- R2: Coarse cell j (0..30) has `coarse_on_o[j]`=1 exactly when the field `code_i[11:7]` is greater than j.
- R3: Middle cell j (0..14) has `mid_on_o[j]`=1 exactly when the field `code_i[6:3]` is greater than j.
- R4: `lsb_on_o[2:0]` equals `code_i[2:0]`, with bit b driving the cell of weight 2^b.
- R5: In every cycle, each `*_off_o` bus is the bitwise inverse of its `*_on_o` bus.
- R6: A synchronous active-high `rst` clears both register stages. After a reset edge, every `*_on_o` bit is 0 and every `*_off_o` bit is 1, which is the pattern for code zero.
- R7: popcount(`coarse_on_o`)·128 + popcount(`mid_on_o`)·8 + `lsb_on_o` equals the code latched two edges earlier, for all 4096 codes.
- R8: Each thermometer bus fills from bit 0 upward. No bit j+1 is set while bit j is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 12 | Sample word to convert |
| coarse_on_o | output | 31 | Coarse cells steered to the primary node |
| coarse_off_o | output | 31 | Coarse cells steered to the complementary node |
| mid_on_o | output | 15 | Middle cells steered to the primary node |
| mid_off_o | output | 15 | Middle cells steered to the complementary node |
| lsb_on_o | output | 3 | Binary cells steered to the primary node |
| lsb_off_o | output | 3 | Binary cells steered to the complementary node |

## Verification
The properties assume that `code_i` is a known value at every rising edge and that `rst` is sampled only on that edge. The value checks compare against the code from two edges earlier. They are therefore gated by a count of edges since reset, so the outputs during pipeline fill, which still reflect the cleared latch, are not compared against stale input. The bench changes `code_i` and `rst` only on falling edges, keeps every word within the 12-bit range, and sweeps all 4096 codes back to back so that each code is checked against its neighbour's transition.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  // Default field split of the sample word.
  localparam int DEF_DATA_W   = 12;
  localparam int DEF_COARSE_W = 5;
  localparam int DEF_MID_W    = 4;

  // Number of unit cells a thermometer field of width w controls.
  function automatic int therm_cells(input int w);
    return (1 << w) - 1;
  endfunction

  // Binary weight of one unit cell in a field whose lowest bit sits at pos.
  function automatic int cell_weight(input int pos);
    return 1 << pos;
  endfunction

endpackage

// File: rtl/segdac_in_latch.sv
// First pipeline stage: captures the sample word on the rising edge.
module segdac_in_latch #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] code_i,
  output logic [DATA_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else begin
      code_q <= code_i;
    end
  end

endmodule

// File: rtl/segdac_therm_seg.sv
// One thermometer segment: decodes a W-bit field into 2^W-1 unit-cell
// controls and registers the primary drive and its complement as two
// separate flop banks, so both change on the same edge.
module segdac_therm_seg #(
  parameter int W     = 4,
  parameter int CELLS = (1 << W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     field_i,
  output logic [CELLS-1:0] on_o,
  output logic [CELLS-1:0] off_o
);

  logic [CELLS-1:0] fill;

  // Cell k is active when the field value exceeds k.
  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    assign fill[k] = (field_i > W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_o  <= '0;
      off_o <= '1;
    end else begin
      on_o  <= fill;
      off_o <= ~fill;
    end
  end

endmodule

// File: rtl/segdac_bin_seg.sv
// Binary-weighted segment: bits pass straight to their cells, registered
// together with a complement bank.
module segdac_bin_seg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] field_i,
  output logic [W-1:0] on_o,
  output logic [W-1:0] off_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_o  <= '0;
      off_o <= '1;
    end else begin
      on_o  <= field_i;
      off_o <= ~field_i;
    end
  end

endmodule

// File: rtl/segdac_switch_driver.sv
// Top: latch -> field split -> two thermometer segments + binary segment.
module segdac_switch_driver #(
  parameter int DATA_W   = segdac_pkg::DEF_DATA_W,
  parameter int COARSE_W = segdac_pkg::DEF_COARSE_W,
  parameter int MID_W    = segdac_pkg::DEF_MID_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           code_i,
  output logic [(1<<COARSE_W)-2:0]    coarse_on_o,
  output logic [(1<<COARSE_W)-2:0]    coarse_off_o,
  output logic [(1<<MID_W)-2:0]       mid_on_o,
  output logic [(1<<MID_W)-2:0]       mid_off_o,
  output logic [DATA_W-COARSE_W-MID_W-1:0] lsb_on_o,
  output logic [DATA_W-COARSE_W-MID_W-1:0] lsb_off_o
);

  localparam int LSB_W      = DATA_W - COARSE_W - MID_W;
  localparam int MID_LO     = LSB_W;
  localparam int COARSE_LO  = LSB_W + MID_W;
  localparam int COARSE_N   = segdac_pkg::therm_cells(COARSE_W);
  localparam int MID_N      = segdac_pkg::therm_cells(MID_W);

  logic [DATA_W-1:0]   code_q;
  logic [COARSE_W-1:0] coarse_field;
  logic [MID_W-1:0]    mid_field;
  logic [LSB_W-1:0]    lsb_field;

  segdac_in_latch #(
    .DATA_W (DATA_W)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .code_i (code_i),
    .code_q (code_q)
  );

  assign coarse_field = code_q[COARSE_LO +: COARSE_W];
  assign mid_field    = code_q[MID_LO +: MID_W];
  assign lsb_field    = code_q[0 +: LSB_W];

  segdac_therm_seg #(
    .W     (COARSE_W),
    .CELLS (COARSE_N)
  ) u_coarse (
    .clk     (clk),
    .rst     (rst),
    .field_i (coarse_field),
    .on_o    (coarse_on_o),
    .off_o   (coarse_off_o)
  );

  segdac_therm_seg #(
    .W     (MID_W),
    .CELLS (MID_N)
  ) u_mid (
    .clk     (clk),
    .rst     (rst),
    .field_i (mid_field),
    .on_o    (mid_on_o),
    .off_o   (mid_off_o)
  );

  segdac_bin_seg #(
    .W (LSB_W)
  ) u_lsb (
    .clk     (clk),
    .rst     (rst),
    .field_i (lsb_field),
    .on_o    (lsb_on_o),
    .off_o   (lsb_off_o)
  );

endmodule

// File: rtl/segdac_switch_driver_chk.sv
// Property checker bound to the top module.
module segdac_switch_driver_chk #(
  parameter int DATA_W   = 12,
  parameter int COARSE_W = 5,
  parameter int MID_W    = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [DATA_W-1:0]           code_i,
  input logic [(1<<COARSE_W)-2:0]    coarse_on_o,
  input logic [(1<<COARSE_W)-2:0]    coarse_off_o,
  input logic [(1<<MID_W)-2:0]       mid_on_o,
  input logic [(1<<MID_W)-2:0]       mid_off_o,
  input logic [DATA_W-COARSE_W-MID_W-1:0] lsb_on_o,
  input logic [DATA_W-COARSE_W-MID_W-1:0] lsb_off_o
);

  localparam int LSB_W     = DATA_W - COARSE_W - MID_W;
  localparam int COARSE_LO = LSB_W + MID_W;

  logic [1:0] since_rst_q;
  logic       seen_q = 1'b0;
  logic       rst_q  = 1'b0;

  always_ff @(posedge clk) begin
    seen_q <= 1'b1;
    rst_q  <= rst;
    if (rst) begin
      since_rst_q <= '0;
    end else if (since_rst_q != 2'd3) begin
      since_rst_q <= since_rst_q + 2'd1;
    end
  end

  // R5: complementary drive
  assert_pair_inverse_R5: assert property (@(posedge clk) disable iff (rst)
    (coarse_off_o == ~coarse_on_o) && (mid_off_o == ~mid_on_o) &&
    (lsb_off_o == ~lsb_on_o));

  // R6: reset leaves every cell on the complementary node
  assert_reset_clear_R6: assert property (@(posedge clk)
    (seen_q && rst_q) |-> ((coarse_on_o == '0) && (mid_on_o == '0) &&
    (lsb_on_o == '0) && (coarse_off_o == '1) && (mid_off_o == '1) &&
    (lsb_off_o == '1)));

  // R2: coarse count follows the upper field with two-edge latency
  assert_coarse_count_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q >= 2'd2) |->
    ($countones(coarse_on_o) == int'($past(code_i[COARSE_LO +: COARSE_W], 2))));

  // R3: middle count follows the middle field
  assert_mid_count_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q >= 2'd2) |->
    ($countones(mid_on_o) == int'($past(code_i[LSB_W +: MID_W], 2))));

  // R4: binary bits pass through
  assert_lsb_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q >= 2'd2) |-> (lsb_on_o == $past(code_i[0 +: LSB_W], 2)));

  // R7: weighted sum matches the code from two edges back
  assert_weighted_sum_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q >= 2'd2) |->
    ($countones(coarse_on_o) * (1 << COARSE_LO) +
     $countones(mid_on_o) * (1 << LSB_W) + int'(lsb_on_o)
       == int'($past(code_i, 2))));

  // R8: thermometer buses fill without gaps
  assert_fill_order_R8: assert property (@(posedge clk) disable iff (rst)
    (((coarse_on_o >> 1) & ~coarse_on_o) == '0) &&
    (((mid_on_o >> 1) & ~mid_on_o) == '0));

endmodule

bind segdac_switch_driver segdac_switch_driver_chk #(
  .DATA_W   (DATA_W),
  .COARSE_W (COARSE_W),
  .MID_W    (MID_W)
) u_chk (.*);

// File: tb/test_segdac_switch_driver.sv
`timescale 1ns/1ps
module test_segdac_switch_driver;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] code_i = '0;
  logic [30:0] coarse_on_o, coarse_off_o;
  logic [14:0] mid_on_o, mid_off_o;
  logic [2:0]  lsb_on_o, lsb_off_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  segdac_switch_driver i_segdac_switch_driver (
    .clk          (clk),
    .rst          (rst),
    .code_i       (code_i),
    .coarse_on_o  (coarse_on_o),
    .coarse_off_o (coarse_off_o),
    .mid_on_o     (mid_on_o),
    .mid_off_o    (mid_off_o),
    .lsb_on_o     (lsb_on_o),
    .lsb_off_o    (lsb_off_o)
  );

  // {code, expected coarse count, expected middle count, expected lsb}
  localparam logic [23:0] VEC [0:7] = '{
    {12'h000, 5'd0,  4'd0,  3'd0},
    {12'hFFF, 5'd31, 4'd15, 3'd7},
    {12'h800, 5'd16, 4'd0,  3'd0},
    {12'h07F, 5'd0,  4'd15, 3'd7},
    {12'h080, 5'd1,  4'd0,  3'd0},
    {12'h5A3, 5'd11, 4'd4,  3'd3},
    {12'h008, 5'd0,  4'd1,  3'd0},
    {12'hF85, 5'd31, 4'd0,  3'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare all outputs against the pattern implied by the three counts.
  task automatic chk_pattern(input int cc, input int mc, input int lc);
    logic [30:0] ec;
    logic [14:0] em;
    ec = (31'(1) << cc) - 31'(1);
    em = (15'(1) << mc) - 15'(1);
    chk("R2 coarse", 32'(coarse_on_o), 32'(ec));
    chk("R3 middle", 32'(mid_on_o), 32'(em));
    chk("R4 lsb", 32'(lsb_on_o), 32'(lc));
    chk("R5 complement", 32'({coarse_off_o ^ coarse_on_o, mid_off_o ^ mid_on_o}),
        32'({31'h7FFFFFFF, 15'h7FFF}) & 32'hFFFFFFFF);
    chk("R5 lsb complement", 32'(lsb_off_o ^ lsb_on_o), 32'd7);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [11:0] hist [0:4097];
    // Reset state (R6)
    repeat (3) @(negedge clk);
    chk("R6 coarse on", 32'(coarse_on_o), 32'd0);
    chk("R6 coarse off", 32'(coarse_off_o), 32'h7FFFFFFF);
    chk("R6 mid off", 32'(mid_off_o), 32'h7FFF);
    chk("R6 lsb off", 32'(lsb_off_o), 32'd7);
    rst = 1'b0;

    // Table walk (R2, R3, R4, R5)
    for (int i = 0; i < 8; i++) begin
      code_i = VEC[i][23:12];
      @(negedge clk);
      @(negedge clk);
      chk_pattern(int'(VEC[i][11:7]), int'(VEC[i][6:3]), int'(VEC[i][2:0]));
    end

    // R1: latency of two edges, hold afterwards
    code_i = 12'h000;
    repeat (3) @(negedge clk);
    code_i = 12'hFFF;
    @(negedge clk);
    chk("R1 one edge later unchanged", 32'(coarse_on_o), 32'd0);
    @(negedge clk);
    chk("R1 two edges later updated", 32'(coarse_on_o), 32'h7FFFFFFF);
    @(negedge clk);
    chk("R1 holds", 32'({mid_on_o, lsb_on_o}), 32'h3FFFF);

    // R6: mid-stream reset clears after one edge
    rst = 1'b1;
    @(negedge clk);
    chk("R6 mid-stream coarse", 32'(coarse_on_o), 32'd0);
    chk("R6 mid-stream mid", 32'(mid_on_o), 32'd0);
    chk("R6 mid-stream lsb off", 32'(lsb_off_o), 32'd7);
    rst = 1'b0;
    code_i = 12'h000;
    repeat (2) @(negedge clk);

    // Full sweep, one code per clock (R7, R8, R5)
    for (int i = 0; i < 4098; i++) begin
      if (i >= 2) begin
        int sum;
        sum = $countones(coarse_on_o) * 128 + $countones(mid_on_o) * 8 + int'(lsb_on_o);
        chk("R7 weighted sum", 32'(sum), 32'(hist[i-2]));
        chk("R8 fill order", 32'({((coarse_on_o >> 1) & ~coarse_on_o),
                                  1'b0}) | 32'((mid_on_o >> 1) & ~mid_on_o), 32'd0);
        chk("R5 sweep complement", 32'(mid_off_o ^ mid_on_o), 32'h7FFF);
      end
      hist[i] = 12'(i);
      code_i  = 12'(i);
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule